// File: doc/BRIEF.md
# Interleaved Bank Contention Model

This block is a cycle-based hardware model of a set of requesters that share a set of interleaved memory banks. It measures how much of the offered request rate the banks can actually serve. In every enabled cycle each requester draws a bank index from its own pseudo-random generator. Each bank accepts at most one of the requests that land on it. Every other request is thrown away, and nothing waits for a later cycle.

Three counters accumulate over the run: the requests offered, the requests served and the cycles elapsed. Software or a bench reads them to get the average number of busy banks per cycle and the ratio of served to offered requests. It then compares them with the closed-form estimate m[1-(1-1/m)^n]. The per-cycle targets, the grants and the busy vector are visible at the ports, so individual collisions can be examined.

Top module: `bank_contention_model`

## Requirements
- R1: Requester r shows its target bank on `req_bank[r*IDX_W +: IDX_W]`, where IDX_W = log2(NUM_BANKS). The generator steps once per clock edge at which `run` is high. While `run` is low, the targets hold.
- R2: Over a long run, each bank receives within 5% of 1/NUM_BANKS of all requests.
- R3: Bit `grant[b*NUM_REQ + r]` is 1 exactly when `run` is high, requester r targets bank b, and no requester with a lower index targets bank b. Each bank's grant slice is therefore at most one-hot.
- R4: `bank_busy[b]` is 1 when bank b grants a request. `busy_count` equals the number of distinct banks targeted in the current cycle while `run` is high.
- R5: On an edge with `run` high and `clear` low, `offered_total` grows by NUM_REQ, `serviced_total` grows by the `busy_count` of that cycle, and `cycle_total` grows by 1.
- R6: `clear` sets all three counters to zero at the next edge. It takes priority over `run` and leaves the generators untouched.
- R7: After reset, all counters read zero, and with `run` low no grant is active.
- R8: Over a long run, serviced_total/cycle_total lies within 2% of NUM_BANKS*(1-(1-1/NUM_BANKS)^NUM_REQ).
- R9: With `run` low, `grant`, `bank_busy` and `busy_count` are zero and the counters hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| run | input | 1 | Enables one modelled memory cycle per clock |
| clear | input | 1 | Zeroes the counters at the next edge |
| req_bank | output | NUM_REQ*IDX_W | Current target bank of each requester |
| grant | output | NUM_BANKS*NUM_REQ | Per-bank grant vectors, NUM_REQ bits per bank |
| bank_busy | output | NUM_BANKS | Banks serving a request this cycle |
| busy_count | output | BUSY_W | Number of busy banks this cycle |
| offered_total | output | CNT_W | Accumulated offered requests |
| serviced_total | output | CNT_W | Accumulated served requests |
| cycle_total | output | CNT_W | Accumulated enabled cycles |

## Verification
The hardest case to reach is a full collision, where every requester lands on the same bank. Only the lowest-index requester may then win, and the busy count drops to one. The targets come from internal generators, so no input can force this case. The bench therefore runs twenty thousand enabled cycles and checks every cycle's grants against targets it reads from the ports. It counts full collisions to confirm that the case occurred. The same long run also provides the per-bank hit distribution and the busy-bank average, which are compared against the closed-form estimate.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

  // Derive a distinct nonzero 32-bit seed for generator idx
  function automatic logic [31:0] seed_for(input int unsigned idx, input logic [31:0] base);
    logic [31:0] s;
    s = base ^ (32'(idx + 1) * 32'h9E37_79B9);
    s = s ^ (s >> 15);
    s = s * 32'h2C1B_3C6D;
    s = s ^ (s >> 12);
    if (s == 32'd0) s = 32'h0000_0001;
    return s;
  endfunction

  // One step of a 32-bit xorshift generator (13, 17, 5)
  function automatic logic [31:0] xs_step(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

endpackage

// File: rtl/bcm_xorshift.sv
module bcm_xorshift #(
  parameter logic [31:0] SEED  = 32'h1,
  parameter int          IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [IDX_W-1:0] bank_idx
);
  import bcm_pkg::*;

  logic [31:0] state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (step) state_d = xs_step(state_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEED;
    else        state_q <= state_d;
  end

  // Upper bits have the best spread in an xorshift generator
  assign bank_idx = state_q[31 -: IDX_W];
endmodule

// File: rtl/bcm_bank_arb.sv
module bcm_bank_arb #(
  parameter int NUM_REQ = 4,
  parameter int IDX_W   = 3,
  parameter int BANK_ID = 0
) (
  input  logic                     run,
  input  logic [NUM_REQ*IDX_W-1:0] req_bank,
  output logic [NUM_REQ-1:0]       grant_vec,
  output logic                     busy
);
  localparam logic [IDX_W-1:0] MY_ID = IDX_W'(BANK_ID);

  always_comb begin
    logic taken;
    taken     = 1'b0;
    grant_vec = '0;
    for (int r = 0; r < NUM_REQ; r++) begin
      if (run && !taken && req_bank[r*IDX_W +: IDX_W] == MY_ID) begin
        grant_vec[r] = 1'b1;
        taken        = 1'b1;
      end
    end
    busy = taken;
  end
endmodule

// File: rtl/bcm_counters.sv
module bcm_counters #(
  parameter int NUM_REQ   = 4,
  parameter int NUM_BANKS = 8,
  parameter int CNT_W     = 32,
  parameter int BUSY_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 clear,
  input  logic [NUM_BANKS-1:0] bank_busy,
  output logic [BUSY_W-1:0]    busy_count,
  output logic [CNT_W-1:0]     offered_total,
  output logic [CNT_W-1:0]     serviced_total,
  output logic [CNT_W-1:0]     cycle_total
);
  logic [CNT_W-1:0] off_d, srv_d, cyc_d;
  logic             cnt_en;

  always_comb begin
    busy_count = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      busy_count = busy_count + BUSY_W'(bank_busy[b]);
  end

  assign cnt_en = clear | run;

  always_comb begin
    off_d = offered_total;
    srv_d = serviced_total;
    cyc_d = cycle_total;
    if (clear) begin
      off_d = '0;
      srv_d = '0;
      cyc_d = '0;
    end else if (run) begin
      off_d = offered_total  + CNT_W'(NUM_REQ);
      srv_d = serviced_total + CNT_W'(busy_count);
      cyc_d = cycle_total    + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offered_total  <= '0;
      serviced_total <= '0;
      cycle_total    <= '0;
    end else if (cnt_en) begin
      offered_total  <= off_d;
      serviced_total <= srv_d;
      cycle_total    <= cyc_d;
    end
  end
endmodule

// File: rtl/bank_contention_model.sv
module bank_contention_model #(
  parameter int          NUM_REQ   = 4,
  parameter int          NUM_BANKS = 8,
  parameter int          CNT_W     = 32,
  parameter logic [31:0] SEED_BASE = 32'h1234_5678,
  localparam int         IDX_W     = $clog2(NUM_BANKS),
  localparam int         BUSY_W    = $clog2(NUM_BANKS + 1)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           run,
  input  logic                           clear,
  output logic [NUM_REQ*IDX_W-1:0]       req_bank,
  output logic [NUM_BANKS*NUM_REQ-1:0]   grant,
  output logic [NUM_BANKS-1:0]           bank_busy,
  output logic [BUSY_W-1:0]              busy_count,
  output logic [CNT_W-1:0]               offered_total,
  output logic [CNT_W-1:0]               serviced_total,
  output logic [CNT_W-1:0]               cycle_total
);
  import bcm_pkg::*;

  // Reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic run_g;
  assign run_g = run & rst_int_n;

  genvar gr, gb;
  generate
    for (gr = 0; gr < NUM_REQ; gr++) begin : g_req
      bcm_xorshift #(
        .SEED  (seed_for(gr, SEED_BASE)),
        .IDX_W (IDX_W)
      ) u_gen (
        .clk      (clk),
        .rst_n    (rst_int_n),
        .step     (run_g),
        .bank_idx (req_bank[gr*IDX_W +: IDX_W])
      );
    end

    for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
      bcm_bank_arb #(
        .NUM_REQ (NUM_REQ),
        .IDX_W   (IDX_W),
        .BANK_ID (gb)
      ) u_arb (
        .run       (run_g),
        .req_bank  (req_bank),
        .grant_vec (grant[gb*NUM_REQ +: NUM_REQ]),
        .busy      (bank_busy[gb])
      );
    end
  endgenerate

  bcm_counters #(
    .NUM_REQ   (NUM_REQ),
    .NUM_BANKS (NUM_BANKS),
    .CNT_W     (CNT_W),
    .BUSY_W    (BUSY_W)
  ) u_cnt (
    .clk            (clk),
    .rst_n          (rst_int_n),
    .run            (run_g),
    .clear          (clear),
    .bank_busy      (bank_busy),
    .busy_count     (busy_count),
    .offered_total  (offered_total),
    .serviced_total (serviced_total),
    .cycle_total    (cycle_total)
  );
endmodule

// File: rtl/bcm_checker.sv
module bcm_checker #(
  parameter int NUM_REQ   = 4,
  parameter int NUM_BANKS = 8,
  parameter int CNT_W     = 32,
  parameter int IDX_W     = 3,
  parameter int BUSY_W    = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         run,
  input logic                         clear,
  input logic [NUM_REQ*IDX_W-1:0]     req_bank,
  input logic [NUM_BANKS*NUM_REQ-1:0] grant,
  input logic [NUM_BANKS-1:0]         bank_busy,
  input logic [BUSY_W-1:0]            busy_count,
  input logic [CNT_W-1:0]             offered_total,
  input logic [CNT_W-1:0]             serviced_total,
  input logic [CNT_W-1:0]             cycle_total
);
  genvar gb;
  generate
    for (gb = 0; gb < NUM_BANKS; gb++) begin : g_oh
      // R3
      grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant[gb*NUM_REQ +: NUM_REQ]));
    end
  endgenerate

  // R1
  target_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(req_bank));

  // R5
  cycle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clear) |=> cycle_total == $past(cycle_total) + CNT_W'(1));

  // R5
  serviced_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clear) |=> serviced_total == $past(serviced_total) + CNT_W'($past(busy_count)));

  // R6
  clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (offered_total == '0 && serviced_total == '0 && cycle_total == '0));

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (grant == '0 && bank_busy == '0 && busy_count == '0));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clear) |=> ($stable(offered_total) && $stable(cycle_total)));
endmodule

bind bank_contention_model bcm_checker #(
  .NUM_REQ   (NUM_REQ),
  .NUM_BANKS (NUM_BANKS),
  .CNT_W     (CNT_W),
  .IDX_W     (IDX_W),
  .BUSY_W    (BUSY_W)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_int_n),
  .run            (run),
  .clear          (clear),
  .req_bank       (req_bank),
  .grant          (grant),
  .bank_busy      (bank_busy),
  .busy_count     (busy_count),
  .offered_total  (offered_total),
  .serviced_total (serviced_total),
  .cycle_total    (cycle_total)
);

// File: tb/bank_contention_model_test.sv
module bank_contention_model_test;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NR = 4;
  localparam int NB = 8;
  localparam int IW = 3;
  localparam int CW = 32;
  localparam int BW = 4;
  localparam int LONG_RUN = 20000;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n, run, clear;
  logic [NR*IW-1:0] req_bank;
  logic [NB*NR-1:0] grant;
  logic [NB-1:0]    bank_busy;
  logic [BW-1:0]    busy_count;
  logic [CW-1:0]    offered_total, serviced_total, cycle_total;

  bank_contention_model #(.NUM_REQ(NR), .NUM_BANKS(NB), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .run(run), .clear(clear),
    .req_bank(req_bank), .grant(grant), .bank_busy(bank_busy),
    .busy_count(busy_count), .offered_total(offered_total),
    .serviced_total(serviced_total), .cycle_total(cycle_total));

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;
  longint exp_off, exp_srv, exp_cyc;

  // Vector table: {run, clear, repeat count}
  localparam int NVEC = 9;
  localparam logic [9:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 8'd20}, {1'b0, 1'b0, 8'd5},  {1'b1, 1'b1, 8'd1},
    {1'b1, 1'b0, 8'd30}, {1'b0, 1'b1, 8'd1},  {1'b0, 1'b0, 8'd3},
    {1'b1, 1'b0, 8'd50}, {1'b1, 1'b1, 8'd2},  {1'b1, 1'b0, 8'd10}
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int tgt_of(input int r);
    return int'(req_bank[r*IW +: IW]);
  endfunction

  // One modelled cycle: drive, check combinational grants, then counters
  task automatic step(input bit r, input bit c);
    logic [NR*IW-1:0] prev_tgt;
    logic [NB*NR-1:0] exp_grant;
    int               exp_busy;
    run = r; clear = c;
    #1;
    prev_tgt  = req_bank;
    exp_grant = '0;
    exp_busy  = 0;
    if (r) begin
      for (int b = 0; b < NB; b++) begin
        for (int q = 0; q < NR; q++) begin
          if (tgt_of(q) == b) begin
            exp_grant[b*NR + q] = 1'b1;
            exp_busy++;
            break;
          end
        end
      end
    end
    chk(grant == exp_grant, r ? "R3 grant" : "R9 grant idle", longint'(grant), longint'(exp_grant));
    chk(int'(busy_count) == exp_busy, r ? "R4 busy_count" : "R9 busy idle", longint'(busy_count), exp_busy);
    chk($countones(bank_busy) == exp_busy, "R4 bank_busy", $countones(bank_busy), exp_busy);
    if (c) begin
      exp_off = 0; exp_srv = 0; exp_cyc = 0;
    end else if (r) begin
      exp_off += NR; exp_srv += exp_busy; exp_cyc += 1;
    end
    @(posedge clk);
    @(negedge clk);
    chk(offered_total == CW'(exp_off) && serviced_total == CW'(exp_srv) && cycle_total == CW'(exp_cyc),
        c ? "R6 clear" : (r ? "R5 counters" : "R9 hold"), longint'(serviced_total), exp_srv);
    if (!r) chk(req_bank == prev_tgt, "R1 targets hold", longint'(req_bank), longint'(prev_tgt));
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end

  initial begin
    int     hits [NB];
    int     full_coll;
    int     moves;
    real    q, strecker, avg, ratio;
    logic [NR*IW-1:0] last;

    rst_n = 1'b0; run = 1'b0; clear = 1'b0;
    exp_off = 0; exp_srv = 0; exp_cyc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7: reset state
    chk(offered_total == '0 && serviced_total == '0 && cycle_total == '0, "R7 counters", longint'(cycle_total), 0);
    chk(grant == '0 && busy_count == '0, "R7 grants idle", longint'(grant), 0);

    // Vector table walk
    for (int v = 0; v < NVEC; v++) begin
      for (int k = 0; k < int'(VEC[v][7:0]); k++) step(VEC[v][9], VEC[v][8]);
    end

    // R6: clear does not restart the generators
    last = req_bank;
    step(1'b0, 1'b1);
    chk(req_bank == last, "R6 generators kept", longint'(req_bank), longint'(last));

    // Long run for R2 / R8 and full collision coverage
    for (int b = 0; b < NB; b++) hits[b] = 0;
    full_coll = 0;
    moves = 0;
    for (int n = 0; n < LONG_RUN; n++) begin
      bit same;
      same = 1'b1;
      for (int r = 0; r < NR; r++) begin
        hits[tgt_of(r)]++;
        if (tgt_of(r) != tgt_of(0)) same = 1'b0;
      end
      if (same) full_coll++;
      last = req_bank;
      step(1'b1, 1'b0);
      if (req_bank != last) moves++;
    end

    // R1: targets advance while running
    chk(moves > LONG_RUN / 2, "R1 targets advance", moves, LONG_RUN / 2);

    // R2: uniform spread
    for (int b = 0; b < NB; b++) begin
      real share;
      share = real'(hits[b]) / real'(LONG_RUN * NR);
      chk(share > 0.95 / NB && share < 1.05 / NB, "R2 bank share", hits[b], (LONG_RUN * NR) / NB);
    end

    // R3: full collisions occurred (lowest index won, checked per cycle)
    chk(full_coll > 0, "R3 full collision seen", full_coll, 1);

    // R8: busy average against m[1-(1-1/m)^n]
    q = 1.0;
    for (int r = 0; r < NR; r++) q = q * (1.0 - 1.0 / NB);
    strecker = NB * (1.0 - q);
    avg = real'(serviced_total) / real'(cycle_total);
    ratio = avg / strecker;
    chk(ratio > 0.98 && ratio < 1.02, "R8 busy average x1000",
        longint'(avg * 1000.0), longint'(strecker * 1000.0));
    chk(offered_total == CW'(LONG_RUN * NR), "R5 offered total", longint'(offered_total), LONG_RUN * NR);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule